// File: doc/BRIEF.md
# Serial-Bus Kicked Watchdog Timer

This block is a watchdog timer that needs no dedicated service pin. It samples the clock and data lines of a two-wire serial bus with the system clock and watches for one framing pattern. First the data line falls while the clock line is high. Then the clock line falls. Finally the data line rises while the clock line is high, which closes the pattern with a stop. Each time that pattern completes, the timeout counter starts again from zero. Software that already uses the bus keeps the watchdog alive by running an ordinary transaction that ends in a stop. If no such transaction ends within the selected timeout, the block pulls its active-low watchdog output low.

Both bus lines pass through two-flop synchronisers before any edge is detected. The monitoring path is never gated off, so a kick is accepted even after the watchdog has fired. A valid kick clears an asserted output and restarts the count. A 2-bit select input picks one of four timeout lengths, measured in system-clock cycles. The select input is read live on every cycle.

Top module: `bus_wdt`

## Requirements
- R1: While rst_ni is low, wdt_n_o is high (inactive), whatever the counter state was before; reset acts asynchronously.
- R2: With the default TO_BASE of 16, tsel_i values 0, 1, 2 and 3 select timeouts of 16, 64, 256 and 1024 cycles (TO_BASE shifted left by 2*tsel_i). With no kick, wdt_n_o stays high through the first timeout-1 rising edges after reset release and goes low on the edge numbered timeout.
- R3: Once low, wdt_n_o stays low until a valid kick completes or reset is applied.
- R4: A valid kick is an SDA fall with SCL high, then an SCL fall, then an SDA rise with SCL high. After the restart takes effect, the output stays high for another timeout-1 edges and goes low on the following edge.
- R5: A valid kick that arrives while wdt_n_o is low returns it high, because bus monitoring is never disabled.
- R6: After an arming SDA fall, a stop (SDA rise with SCL high) with no SCL fall between the two has no effect on the timer.
- R7: A stop with no arming SDA fall before it has no effect on the timer. This covers the case where SDA fell while SCL was low.
- R8: With two synchroniser stages, a kick takes effect on the fourth rising edge after the closing SDA rise is applied at the pins, and not before.
- R9: tsel_i is read every cycle. If it is lowered so that the elapsed count already reaches the new limit, wdt_n_o goes low on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial bus clock line, asynchronous to clk_i |
| sda_i | input | 1 | Serial bus data line, asynchronous to clk_i |
| tsel_i | input | 2 | Timeout select code |
| wdt_n_o | output | 1 | Watchdog output, active low (low enables the open-drain pull-down) |

## Verification
The bench checks the exact expiry edge for all four select codes, so a counter that is off by one fires one edge early or late and is reported. It checks the exact edge on which a kick recovers an expired output. A synchroniser or kick register that is missing or added shifts that edge. Two incomplete patterns are driven close to expiry: a stop with no clock fall, and a stop with no arming fall. A detector that accepted either one would keep the output high past the expected expiry edge. The bench also lowers the select code while the counter is well advanced; a design that compared for equality only would miss the limit and never fire.

// File: rtl/bus_wdt_pkg.sv
package bus_wdt_pkg;

  typedef enum logic [1:0] {
    DET_IDLE    = 2'd0,
    DET_ARMED   = 2'd1,
    DET_CLOCKED = 2'd2
  } det_state_e;

  // timeout in cycles for a select code
  function automatic int unsigned wdt_limit(int unsigned base, logic [1:0] sel);
    return base << (2 * int'(sel));
  endfunction

endpackage

// File: rtl/bus_wdt_sync.sv
module bus_wdt_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= {STAGES{RST_VAL[g]}};
      else         sr_q <= {sr_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sr_q[STAGES-1];
  end

endmodule

// File: rtl/bus_wdt_kick_det.sv
module bus_wdt_kick_det
  import bus_wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic kick_o
);

  logic       scl_q, sda_q;
  det_state_e state_q, state_d;
  logic       hit;

  wire sda_fall = sda_q & ~sda_i;
  wire sda_rise = ~sda_q & sda_i;
  wire scl_fall = scl_q & ~scl_i;
  wire start_c  = sda_fall & scl_i;
  wire stop_c   = sda_rise & scl_i;

  always_comb begin
    state_d = state_q;
    hit     = 1'b0;
    if (start_c) begin
      state_d = DET_ARMED;  // any start (re)arms
    end else begin
      unique case (state_q)
        DET_ARMED: begin
          if (stop_c)        state_d = DET_IDLE;  // stop before clock fall: abort
          else if (scl_fall) state_d = DET_CLOCKED;
        end
        DET_CLOCKED: begin
          if (stop_c) begin
            hit     = 1'b1;
            state_d = DET_IDLE;
          end
        end
        default: state_d = DET_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      state_q <= DET_IDLE;
      kick_o  <= 1'b0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      state_q <= state_d;
      kick_o  <= hit;
    end
  end

endmodule

// File: rtl/bus_wdt_timer.sv
module bus_wdt_timer
  import bus_wdt_pkg::*;
#(
  parameter int unsigned TO_BASE = 16,
  parameter int unsigned CNT_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kick_i,
  input  logic [1:0]       tsel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);

  logic [CNT_W-1:0] last;

  always_comb last = CNT_W'(wdt_limit(TO_BASE, tsel_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      expired_o <= 1'b0;
    end else if (kick_i) begin
      cnt_o     <= '0;
      expired_o <= 1'b0;
    end else if (!expired_o) begin
      // >= so a lowered limit still fires
      if (cnt_o >= last) expired_o <= 1'b1;
      else               cnt_o     <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/bus_wdt.sv
module bus_wdt #(
  parameter int unsigned TO_BASE     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] tsel_i,
  output logic       wdt_n_o
);

  localparam int unsigned CNT_W = $clog2(TO_BASE << 6);

  logic [1:0]       bus_s;
  logic             kick;
  logic             expired;
  logic [CNT_W-1:0] cnt;

  bus_wdt_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sda_i, scl_i}),
    .q_o   (bus_s)
  );

  bus_wdt_kick_det u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (bus_s[0]),
    .sda_i (bus_s[1]),
    .kick_o(kick)
  );

  bus_wdt_timer #(
    .TO_BASE(TO_BASE),
    .CNT_W  (CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (kick),
    .tsel_i   (tsel_i),
    .cnt_o    (cnt),
    .expired_o(expired)
  );

  assign wdt_n_o = ~expired;

endmodule

// File: rtl/bus_wdt_chk.sv
module bus_wdt_chk
  import bus_wdt_pkg::*;
#(
  parameter int unsigned TO_BASE = 16,
  parameter int unsigned CNT_W   = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       tsel_i,
  input logic             kick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             wdt_n_i
);

  logic [CNT_W-1:0] last_w;
  always_comb last_w = CNT_W'(wdt_limit(TO_BASE, tsel_i) - 1);

  // R2
  a_r2_no_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_n_i && cnt_i < last_w) |=> wdt_n_i);

  // R2, R9
  a_r9_fire_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_n_i && !kick_i && cnt_i >= last_w) |=> !wdt_n_i);

  // R3
  a_r3_stay_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdt_n_i && !kick_i) |=> (!wdt_n_i && $stable(cnt_i)));

  // R4, R5
  a_r5_kick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (wdt_n_i && cnt_i == '0));

  // R4
  a_r4_kick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !kick_i);

endmodule

bind bus_wdt bus_wdt_chk #(
  .TO_BASE(TO_BASE),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tsel_i (tsel_i),
  .kick_i (kick),
  .cnt_i  (cnt),
  .wdt_n_i(wdt_n_o)
);

// File: tb/tb_bus_wdt.sv
module tb_bus_wdt;

  localparam int unsigned BASE = 16;
  localparam int G = 4;  // cycles between bus line changes

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic [1:0] tsel = 2'd0;
  logic       wdt_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_kick = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_wdt #(.TO_BASE(BASE)) dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .scl_i  (scl),
    .sda_i  (sda),
    .tsel_i (tsel),
    .wdt_n_o(wdt_n)
  );

  function automatic int lim_of(logic [1:0] s);
    return int'(BASE) << (2 * int'(s));
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: wdt_n_o=%b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset(logic [1:0] s);
    rst_ni = 1'b0;
    scl = 1'b1;
    sda = 1'b1;
    tsel = s;
    tick(2);
    rst_ni = 1'b1;
    last_kick = cyc;
  endtask

  // start, clock fall, clock rise; stop left to caller
  task automatic kick_lead();
    sda = 1'b0; tick(G);
    scl = 1'b0; tick(G);
    scl = 1'b1; tick(G);
  endtask

  task automatic bus_kick();
    kick_lead();
    sda = 1'b1; tick(G);
    last_kick = cyc;  // clear lands on 4th edge == now
  endtask

  // start then stop, no clock fall
  task automatic fake_stop();
    sda = 1'b0; tick(G);
    sda = 1'b1; tick(G);
  endtask

  // data falls while clock low, then stop: never armed
  task automatic no_arm_stop();
    scl = 1'b0; tick(G);
    sda = 1'b0; tick(G);
    scl = 1'b1; tick(G);
    sda = 1'b1; tick(G);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(2);
    chk("R1 in reset", wdt_n, 1'b1);

    // R2 exact expiry per select code
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      tick(lim_of(2'(s)) - 1);
      chk("R2 before limit", wdt_n, 1'b1);
      tick(1);
      chk("R2 at limit", wdt_n, 1'b0);
    end

    // R3 holds low
    do_reset(2'd0);
    tick(16 + 50);
    chk("R3 stays low", wdt_n, 1'b0);

    // R8/R5 recovery edge, then R4 restart length
    kick_lead();
    chk("R3 low before stop", wdt_n, 1'b0);
    sda = 1'b1;
    tick(3);
    chk("R8 not before 4th edge", wdt_n, 1'b0);
    tick(1);
    chk("R5 kick clears output", wdt_n, 1'b1);
    tick(16 - 1);
    chk("R4 high after restart", wdt_n, 1'b1);
    tick(1);
    chk("R4 expiry after restart", wdt_n, 1'b0);

    // R6 stop without clock fall
    do_reset(2'd1);
    tick(30);
    fake_stop();
    tick(25);
    chk("R6 high before limit", wdt_n, 1'b1);
    tick(1);
    chk("R6 no restart", wdt_n, 1'b0);

    // R7 stop without arming
    do_reset(2'd1);
    tick(20);
    no_arm_stop();
    tick(27);
    chk("R7 high before limit", wdt_n, 1'b1);
    tick(1);
    chk("R7 no restart", wdt_n, 1'b0);

    // R9 lowered select
    do_reset(2'd3);
    tick(100);
    chk("R9 high at long limit", wdt_n, 1'b1);
    tsel = 2'd0;
    tick(1);
    chk("R9 fires next edge", wdt_n, 1'b0);

    // R1 async reset while expired
    #2 rst_ni = 1'b0;
    #2;
    chk("R1 async reset", wdt_n, 1'b1);

    // random mix against elapsed-cycle model
    for (int b = 0; b < 4; b++) begin
      logic [1:0] s;
      int lim;
      s = 2'($urandom % 4);
      lim = lim_of(s);
      do_reset(s);
      for (int i = 0; i < 40; i++) begin
        int op;
        op = int'($urandom % 4);
        case (op)
          0: bus_kick();
          1: fake_stop();
          2: no_arm_stop();
          default: tick(1 + int'($urandom % (lim / 2)));
        endcase
        if (op == 0) chk("R4 random kick", wdt_n, 1'b1);
        else if (op == 3) chk("R2 random idle", wdt_n, (cyc - last_kick) < lim);
        else chk("R6 R7 random ignored", wdt_n, (cyc - last_kick) < lim);
      end
    end

    done = 1'b1;
    summary();
  end

endmodule